// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. A requester presents the virtual address together with the physical base address of the first-level table. The walker then reads one 4-byte entry from each level over a simple request/response memory port. It reports either the translated address or a page fault that names the level where the walk stopped.

The virtual address is split as 10/10/12. Bits 31:22 pick one of 1024 entries in the first-level table. Bits 21:12 pick one of 1024 entries in the second-level table. Bits 11:0 are the page offset and pass through unchanged. Each table is 4096 bytes. An entry carries its valid flag in bit 0 and a 20-bit frame number in bits 29:10. Bits 31:30 and 9:1 have no effect on the walk. A valid first-level entry gives the base of the second-level table, which is the frame number followed by twelve zero bits. A valid second-level entry gives the physical frame. An invalid entry at either level ends the walk with a fault, so that software can bring in the missing page.

Only one walk runs at a time, and only one memory read is outstanding. The block does no caching of translations and checks no permissions.

Top module: `pt_walker`

## Requirements
- R1: While and right after `rst` is high, `req_ready` is 1 and `mem_req_valid`, `done_ok` and `fault` are 0.
- R2: A request is taken only when `req_ready` is 1, which means idle. During a walk `req_ready` is 0, and a `req_valid` with a different address has no effect on the result.
- R3: The first read goes to `root_base + vaddr[31:22]*4`.
- R4: If bit 0 of the first-level entry is 0, the walk ends with `fault`=1, `fault_level`=0 and `result_addr` equal to the virtual address. No second read is issued.
- R5: If the first-level entry is valid, the second read goes to `{entry[29:10], 12'h000} + vaddr[21:12]*4`. Entry bits 31:30 and 9:1 are ignored.
- R6: If bit 0 of the second-level entry is 0, the walk ends after exactly two reads with `fault`=1, `fault_level`=1 and `result_addr` equal to the virtual address.
- R7: If the second-level entry is valid, the walk ends with `done_ok`=1 and `result_addr = {entry[29:10], vaddr[11:0]}`.
- R8: Each accepted request gives exactly one of `done_ok` or `fault`, high for exactly one cycle. The walker is ready again in the next cycle.
- R9: A memory read holds `mem_req_valid` and a stable `mem_req_addr` until `mem_req_ready` is seen. The walker then waits any number of cycles for `mem_rsp_valid` before going on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base address of the first-level table, sampled with the request |
| mem_req_valid | output | 1 | Memory word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_ok | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | Level of the invalid entry (0 first, 1 second), valid with `fault` |
| result_addr | output | 32 | Physical address with `done_ok`, virtual address with `fault` |

## Verification
The hardest case to reach from the ports is a new request that arrives while a walk is already running. It must stay unaccepted and must not disturb the walk in progress. The memory handshake must also be stretched in every stall and latency combination at both levels. The bench plays the part of memory. It builds every table entry arithmetically from its address, so each walk can be predicted. On odd walks it keeps `req_valid` high with the inverted address for the whole walk. It rotates the ready stall (0 to 2 cycles) and the response latency (0 to 3 cycles) from one read to the next. Two sweeps cover all 1024 first-level indices and all 1024 second-level indices under two table roots. Together they hit valid and invalid entries at both levels.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_WT1,
    ST_RD2,
    ST_WT2,
    ST_DONE
  } walk_state_t;

endpackage

// File: rtl/ptw_entry_addr.sv
// Byte address of one table entry: table base plus index scaled by entry size.
module ptw_entry_addr #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [ADDR_W-1:0] table_base,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int SH  = $clog2(ENTRY_BYTES);
  localparam int PAD = ADDR_W - IDX_W - SH;

  logic [ADDR_W-1:0] scaled;

  assign scaled     = {{PAD{1'b0}}, index, {SH{1'b0}}};
  assign entry_addr = table_base + scaled;
endmodule

// File: rtl/ptw_pte_split.sv
// Pulls the valid flag and frame number out of a raw table entry.
module ptw_pte_split #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 20,
  parameter int PPN_LSB = 10
) (
  input  logic [PTE_W-1:0]   pte,
  output logic               pte_valid,
  output logic [FRAME_W-1:0] pte_frame
);
  logic unused_bits;

  assign pte_valid   = pte[0];
  assign pte_frame   = pte[PPN_LSB +: FRAME_W];
  assign unused_bits = ^{pte[PTE_W-1:PPN_LSB+FRAME_W], pte[PPN_LSB-1:1]};
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: one outstanding read, registered outcome.
module ptw_ctrl
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  l1_addr,
  input  logic [ADDR_W-1:0]  l2_addr,
  input  logic               pte_valid,
  input  logic [FRAME_W-1:0] pte_frame,
  output logic [ADDR_W-1:0]  vaddr_q,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               done_ok,
  output logic               fault,
  output logic               fault_level,
  output logic [ADDR_W-1:0]  result_addr
);
  walk_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      vaddr_q     <= '0;
      done_ok     <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      result_addr <= '0;
    end else begin
      done_ok <= 1'b0;
      fault   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            addr_q  <= l1_addr;
            state_q <= ST_RD1;
          end
        end
        ST_RD1: begin
          if (mem_req_ready) state_q <= ST_WT1;
        end
        ST_WT1: begin
          if (mem_rsp_valid) begin
            if (pte_valid) begin
              addr_q  <= l2_addr;
              state_q <= ST_RD2;
            end else begin
              fault       <= 1'b1;
              fault_level <= 1'b0;
              result_addr <= vaddr_q;
              state_q     <= ST_DONE;
            end
          end
        end
        ST_RD2: begin
          if (mem_req_ready) state_q <= ST_WT2;
        end
        ST_WT2: begin
          if (mem_rsp_valid) begin
            if (pte_valid) begin
              done_ok     <= 1'b1;
              result_addr <= {pte_frame, vaddr_q[OFF_W-1:0]};
            end else begin
              fault       <= 1'b1;
              fault_level <= 1'b1;
              result_addr <= vaddr_q;
            end
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int PTE_W       = 32,
  parameter int PPN_LSB     = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_ok,
  output logic              fault,
  output logic              fault_level,
  output logic [ADDR_W-1:0] result_addr
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int LEVELS  = 2;

  logic [FRAME_W-1:0] pte_frame;
  logic               pte_valid;
  logic [ADDR_W-1:0]  vaddr_q;
  logic [ADDR_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0]   lvl_idx  [LEVELS];
  logic [ADDR_W-1:0]  lvl_addr [LEVELS];

  ptw_pte_split #(
    .PTE_W  (PTE_W),
    .FRAME_W(FRAME_W),
    .PPN_LSB(PPN_LSB)
  ) u_split (
    .pte      (mem_rsp_data),
    .pte_valid(pte_valid),
    .pte_frame(pte_frame)
  );

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int IDX_LSB = OFF_W + IDX_W * (LEVELS - 1 - lv);
    if (lv == 0) begin : g_root
      assign lvl_base[lv] = root_base;
      assign lvl_idx[lv]  = req_vaddr[IDX_LSB +: IDX_W];
    end else begin : g_next
      assign lvl_base[lv] = {pte_frame, {OFF_W{1'b0}}};
      assign lvl_idx[lv]  = vaddr_q[IDX_LSB +: IDX_W];
    end
    ptw_entry_addr #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .ENTRY_BYTES(ENTRY_BYTES)
    ) u_eaddr (
      .table_base(lvl_base[lv]),
      .index     (lvl_idx[lv]),
      .entry_addr(lvl_addr[lv])
    );
  end

  ptw_ctrl #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_ready    (req_ready),
    .l1_addr      (lvl_addr[0]),
    .l2_addr      (lvl_addr[1]),
    .pte_valid    (pte_valid),
    .pte_frame    (pte_frame),
    .vaddr_q      (vaddr_q),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .done_ok      (done_ok),
    .fault        (fault),
    .fault_level  (fault_level),
    .result_addr  (result_addr)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [ADDR_W-1:0] root_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [PTE_W-1:0]  mem_rsp_data,
  input logic              done_ok,
  input logic              fault,
  input logic              fault_level,
  input logic [ADDR_W-1:0] result_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_req_valid && !done_ok && !fault));

  assert_idle_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  assert_read_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_ok && fault));

  assert_outcome_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (done_ok || fault) |=> (!done_ok && !fault && req_ready));

  assert_outcome_not_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (done_ok || fault) |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam logic [31:0] ROOT_A = 32'h0000_2000;
  localparam logic [31:0] ROOT_B = 32'h0003_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_ok;
  logic        fault;
  logic        fault_level;
  logic [31:0] result_addr;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_ok(done_ok), .fault(fault),
    .fault_level(fault_level), .result_addr(result_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory contents are a pure function of the byte address.
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [9:0]  ix;
    logic [19:0] pg;
    logic [19:0] fr;
    int t;
    ix = a[11:2];
    pg = a[31:12];
    if (pg == ROOT_A[31:12] || pg == ROOT_B[31:12]) begin
      fr = 20'h00100 + {10'd0, (pg == ROOT_A[31:12]) ? ix : (ix ^ 10'h155)};
      return {ix[1:0], fr, ix[8:0], (ix % 3) != 0};
    end else if (pg >= 20'h00100 && pg < 20'h00500) begin
      t  = int'(pg) - 32'h100;
      fr = 20'((t * 7 + int'(ix) * 13 + 32'hA5A5) & 32'hFFFFF);
      return {2'b11, fr, 9'h1AA, ((int'(ix) + t) % 5) != 0};
    end
    return 32'h0;
  endfunction

  task automatic run_walk(input logic [31:0] root, input logic [31:0] va, input int n);
    logic [31:0] e_addr [2];
    logic [31:0] p1, p2, e_res, paddr;
    int  e_reads, reads, stall, lat, guard;
    bit  e_ok, e_lvl, pending, seen;
    e_addr[0] = root + {20'd0, va[31:22], 2'b00};
    p1 = pte_of(e_addr[0]);
    e_addr[1] = {p1[29:10], 12'h000} + {20'd0, va[21:12], 2'b00};
    p2 = pte_of(e_addr[1]);
    if (!p1[0]) begin
      e_reads = 1; e_ok = 0; e_lvl = 0; e_res = va;
    end else if (!p2[0]) begin
      e_reads = 2; e_ok = 0; e_lvl = 1; e_res = va;
    end else begin
      e_reads = 2; e_ok = 1; e_lvl = 0; e_res = {p2[29:10], va[11:0]};
    end
    reads = 0; pending = 0; seen = 0; guard = 0; lat = 0; paddr = '0;
    @(negedge clk);
    chk("R2 ready when idle", {31'd0, req_ready}, 32'd1);
    root_base = root; req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    if (n % 2 == 1) req_vaddr = ~va;   // R2: competing request held during the walk
    else req_valid = 1'b0;
    stall = n % 3;
    while (!seen && guard < 300) begin
      guard++;
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (done_ok || fault) begin
        seen = 1;
        req_valid = 1'b0;
      end else begin
        if (req_ready) chk("R2 busy not ready", 32'd1, 32'd0);
        if (mem_req_valid) begin
          if (stall > 0) stall--;
          else begin
            if (reads < e_reads)
              chk(reads == 0 ? "R3 first read addr" : "R5 second read addr",
                  mem_req_addr, e_addr[reads]);
            else chk("R4/R6 extra read", 32'(reads + 1), 32'(e_reads));
            paddr = mem_req_addr;
            reads++;
            mem_req_ready = 1'b1;
            pending = 1;
            lat = (n + reads) % 4;
            stall = (n + reads + 1) % 3;
          end
        end else if (pending) begin
          if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pte_of(paddr);
            pending = 0;
          end else lat--;
        end
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) begin
      chk("R9 walk finished", 32'd0, 32'd1);
      return;
    end
    chk(e_ok ? "R7 done_ok" : "R4/R6 done_ok", {31'd0, done_ok}, {31'd0, e_ok});
    chk("R8 fault flag", {31'd0, fault}, {31'd0, !e_ok});
    chk(e_ok ? "R7 result" : "R4/R6 result", result_addr, e_res);
    chk(e_reads == 1 ? "R4 read count" : "R6 read count", 32'(reads), 32'(e_reads));
    if (!e_ok) chk("R4/R6 fault_level", {31'd0, fault_level}, {31'd0, e_lvl});
    @(negedge clk);
    chk("R8 one-cycle pulse", {30'd0, done_ok, fault}, 32'd0);
    chk("R8 ready after outcome", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no fetch in reset", {31'd0, mem_req_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, req_ready, mem_req_valid, done_ok | fault}, 32'd4);
    // Sweep 1: every first-level index, mixed second-level index and offset.
    for (int i = 0; i < 1024; i++)
      run_walk(ROOT_A, {10'(i), 10'((i * 37) % 1024), 12'((i * 91) % 4096)}, i);
    // Sweep 2: every second-level index under one valid first-level entry.
    for (int j = 0; j < 1024; j++)
      run_walk(ROOT_B, {10'd1, 10'(j), 12'((j * 5) % 4096)}, j + 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule